// File: doc/BRIEF.md
# Data Segment Cache Revalidation Sequencer

When a far return or an interrupt return drops the processor to an outer, numerically higher privilege level, the data segment registers may still hold descriptors that the new level is not allowed to use. This block sweeps the four cached data segment entries one at a time, in a fixed order. It reads each entry's flags word and issues a null-load command for every entry that has become too privileged. It never raises a fault. An entry that fails the check is only invalidated.

The caller pulses `start` together with the privilege level in force before the return and the level being returned to. The block reads the cache through `rd_idx`/`rd_flags`. When an entry is stale, it pulses `clr_en` with the entry number in `clr_idx`. The cache owner must then replace that entry with a null one: selector, base, limit and flags all zero. When the sweep is over, `done` pulses for one cycle. If the return does not move outward, the sweep is skipped and no entry is touched.

Top module: `seg_revalidate`

## Requirements
- R1: Entries are visited one per cycle in the fixed order ES, DS, FS, GS, numbered 0, 1, 2, 3 on `rd_idx` and `clr_idx`. If `start` is sampled in cycle S, entry k is read in cycle S+1+k, and its clear pulse, if any, appears in cycle S+2+k.
- R2: The descriptor privilege level of an entry is taken from bits 14:13 of its flags word.
- R3: An entry whose flags have both bit 11 (code) and bit 10 (conforming) set is never cleared, whatever its privilege level.
- R4: Any other entry whose privilege level is below the new level gets a one-cycle `clr_en` pulse carrying its number. This covers data segments, non-conforming code and all-zero flags.
- R5: An entry whose privilege level is equal to or above the new level is left alone, and no clear pulse is issued for it.
- R6: If the new level is not greater than the old level, no entry is read for clearing and no clear is issued. `done` pulses in cycle S+1.
- R7: After an outward return, `done` pulses for exactly one cycle in cycle S+6, the cycle after the last entry's clear slot. It never coincides with a clear pulse.
- R8: A `start` pulse that arrives while a sweep is running is ignored. The new level is captured at the accepted `start`, so later changes on the level inputs do not affect the running sweep.
- R9: After reset, `done` and `clr_en` are low and `rd_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a revalidation after a return |
| old_cpl | input | CPL_W | Privilege level before the return |
| new_cpl | input | CPL_W | Privilege level after the return |
| rd_idx | output | SEL_W | Entry number being read (0 ES, 1 DS, 2 FS, 3 GS) |
| rd_flags | input | FLAGS_W | Flags word of the entry selected by `rd_idx` |
| clr_en | output | 1 | Command to null the entry in `clr_idx` |
| clr_idx | output | SEL_W | Entry to null |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Some properties are checked by assertions on every cycle:
- clear pulses follow each other in ascending entry order;
- a conforming code entry is never followed by a clear;
- a stale entry is always followed by a clear carrying its number;
- `done` is a lone pulse that never overlaps a clear;
- a skipped sweep finishes at once, and a restart during a sweep leaves it running.

Other behaviour can only be shown by the scoreboard scenarios:
- the exact cycle of each pulse relative to `start`;
- the final contents of the modelled cache;
- the boundary where the descriptor level equals the new level;
- the fact that a sweep keeps the level captured at `start` when a second `start` arrives mid-sweep with different levels.

// File: rtl/seg_reval_pkg.sv
package seg_reval_pkg;
  // Field positions inside a cached descriptor flags word
  localparam int DPL_LO   = 13;  // privilege level in [DPL_LO+1:DPL_LO]
  localparam int CODE_BIT = 11;  // executable segment
  localparam int CONF_BIT = 10;  // conforming code
  localparam int SYS_BIT  = 12;  // descriptor type, not used here
endpackage

// File: rtl/seg_priv_check.sv
module seg_priv_check #(
  parameter int CPL_W = 2
) (
  input  logic [CPL_W-1:0] dpl,
  input  logic             is_code,
  input  logic             is_conf,
  input  logic [CPL_W-1:0] cpl,
  output logic             stale
);
  // Conforming code is exempt; everything else must not be more privileged
  always_comb begin
    stale = 1'b0;
    if (!(is_code && is_conf))
      stale = (dpl < cpl);
  end
endmodule

// File: rtl/seg_sweep_ctrl.sv
module seg_sweep_ctrl #(
  parameter int NUM_SEGS = 4,
  parameter int CPL_W    = 2,
  localparam int STEP_W  = $clog2(NUM_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CPL_W-1:0]  old_cpl,
  input  logic [CPL_W-1:0]  new_cpl,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              check_en,
  output logic [CPL_W-1:0]  cpl_q,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_SEGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      cpl_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (new_cpl > old_cpl) begin
            busy  <= 1'b1;
            step  <= '0;
            cpl_q <= new_cpl;
          end else begin
            done <= 1'b1;
          end
        end
      end else if (step == LAST_STEP) begin
        busy <= 1'b0;
        step <= '0;
        done <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign check_en = busy && (step != LAST_STEP);

  // R6: a non-outward return finishes at once without a sweep
  p_skip_done_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !(new_cpl > old_cpl)) |=> (done && !busy));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: start during a running sweep does not disturb it
  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (check_en && start) |=> (busy && $stable(cpl_q)));

  // R1: steps advance by one per cycle
  p_step_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && step != '0) |-> (step == $past(step) + 1'b1));
endmodule

// File: rtl/seg_revalidate.sv
module seg_revalidate
  import seg_reval_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int CPL_W    = 2,
  parameter int FLAGS_W  = 32,
  localparam int SEL_W   = $clog2(NUM_SEGS),
  localparam int STEP_W  = $clog2(NUM_SEGS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CPL_W-1:0]   old_cpl,
  input  logic [CPL_W-1:0]   new_cpl,
  output logic [SEL_W-1:0]   rd_idx,
  input  logic [FLAGS_W-1:0] rd_flags,
  output logic               clr_en,
  output logic [SEL_W-1:0]   clr_idx,
  output logic               done
);
  logic              busy;
  logic [STEP_W-1:0] step;
  logic              check_en;
  logic [CPL_W-1:0]  cpl_q;
  logic              stale;
  logic [CPL_W-1:0]  ent_dpl;
  logic              ent_code;
  logic              ent_conf;
  logic              unused_flag_bits;

  seg_sweep_ctrl #(.NUM_SEGS(NUM_SEGS), .CPL_W(CPL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .old_cpl  (old_cpl),
    .new_cpl  (new_cpl),
    .busy     (busy),
    .step     (step),
    .check_en (check_en),
    .cpl_q    (cpl_q),
    .done     (done)
  );

  assign rd_idx   = check_en ? step[SEL_W-1:0] : '0;
  assign ent_dpl  = rd_flags[DPL_LO +: CPL_W];
  assign ent_code = rd_flags[CODE_BIT];
  assign ent_conf = rd_flags[CONF_BIT];
  assign unused_flag_bits = ^{rd_flags[FLAGS_W-1:DPL_LO+CPL_W],
                              rd_flags[SYS_BIT], rd_flags[CONF_BIT-1:0]};

  seg_priv_check #(.CPL_W(CPL_W)) u_check (
    .dpl     (ent_dpl),
    .is_code (ent_code),
    .is_conf (ent_conf),
    .cpl     (cpl_q),
    .stale   (stale)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_en  <= 1'b0;
      clr_idx <= '0;
    end else begin
      clr_en  <= check_en && stale;
      clr_idx <= rd_idx;
    end
  end

  // R1: successive clear commands target ascending entries
  p_clear_order_r1: assert property (@(posedge clk) disable iff (rst)
    (clr_en && $past(clr_en)) |-> (clr_idx == $past(clr_idx) + 1'b1));

  // R3: a conforming code entry is never nulled
  p_conforming_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (check_en && rd_flags[CODE_BIT] && rd_flags[CONF_BIT]) |=> !clr_en);

  // R4: a too-privileged non-conforming entry is nulled next cycle
  p_stale_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    (check_en && !(rd_flags[CODE_BIT] && rd_flags[CONF_BIT]) &&
     (rd_flags[DPL_LO +: CPL_W] < cpl_q))
    |=> (clr_en && clr_idx == $past(rd_idx)));

  // R7: completion never overlaps a clear command
  p_done_alone_r7: assert property (@(posedge clk) disable iff (rst)
    !(clr_en && done));
endmodule

// File: tb/tb_seg_revalidate.sv
`timescale 1ns/1ps
module tb_seg_revalidate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  old_cpl = '0;
  logic [1:0]  new_cpl = '0;
  logic [1:0]  rd_idx;
  logic [31:0] rd_flags;
  logic        clr_en;
  logic [1:0]  clr_idx;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    bit    is_done;
    int    idx;
    int    when;
    string req;
  } ev_t;
  ev_t evq[$];

  logic [31:0] cache_flags [4];
  logic [15:0] cache_sel   [4];
  logic        ld_en = 1'b0;
  logic [31:0] ld_flags [4];

  always #2 clk = ~clk;

  seg_revalidate dut (
    .clk(clk), .rst(rst), .start(start), .old_cpl(old_cpl), .new_cpl(new_cpl),
    .rd_idx(rd_idx), .rd_flags(rd_flags), .clr_en(clr_en), .clr_idx(clr_idx),
    .done(done)
  );

  assign rd_flags = cache_flags[rd_idx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld_en) begin
      for (int k = 0; k < 4; k++) begin
        cache_flags[k] <= ld_flags[k];
        cache_sel[k]   <= 16'h0040 + 16'(k * 8);
      end
    end else if (clr_en) begin
      cache_flags[clr_idx] <= '0;
      cache_sel[clr_idx]   <= '0;
    end
  end

  function automatic logic [31:0] mk(input int dpl, input bit code, input bit conf);
    mk = 32'h0000_9200 | (32'(dpl) << 13) | (32'(code) << 11) | (32'(conf) << 10);
  endfunction

  function automatic bit is_stale(input logic [31:0] f, input logic [1:0] lvl);
    if (f[11] && f[10]) return 1'b0;
    return f[14:13] < lvl;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compare design events against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (clr_en) observe(1'b0, int'(clr_idx));
      if (done)   observe(1'b1, 0);
    end
  end

  task automatic observe(input bit is_done, input int idx);
    ev_t e;
    if (evq.size() == 0) begin
      chk(1'b0, "R8", is_done ? "unexpected done at cycle" : "unexpected clear at cycle",
          cyc, -1);
    end else begin
      e = evq.pop_front();
      chk(e.is_done == is_done, e.req, "event kind (1=done)", is_done, e.is_done);
      chk(e.idx == idx, e.req, "entry index", idx, e.idx);
      chk(e.when == cyc, e.req, "event cycle", cyc, e.when);
    end
  endtask

  // Driver: load cache, start a sweep, predict events, verify cache afterwards
  task automatic run(input logic [1:0] oc, input logic [1:0] nc,
                     input logic [31:0] f0, input logic [31:0] f1,
                     input logic [31:0] f2, input logic [31:0] f3,
                     input bit poke, input string req);
    logic [31:0] fv [4];
    int s;
    ev_t e;
    fv[0] = f0; fv[1] = f1; fv[2] = f2; fv[3] = f3;
    for (int k = 0; k < 4; k++) ld_flags[k] = fv[k];
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    old_cpl = oc;
    new_cpl = nc;
    start = 1'b1;
    s = cyc;
    if (nc > oc) begin
      for (int k = 0; k < 4; k++) begin
        if (is_stale(fv[k], nc)) begin
          e.is_done = 1'b0; e.idx = k; e.when = s + 2 + k; e.req = "R4";
          evq.push_back(e);
        end
      end
      e.is_done = 1'b1; e.idx = 0; e.when = s + 6; e.req = "R7";
      evq.push_back(e);
    end else begin
      e.is_done = 1'b1; e.idx = 0; e.when = s + 1; e.req = "R6";
      evq.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      old_cpl = 2'd3;
      new_cpl = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < s + 10) @(negedge clk);
    chk(evq.size() == 0, req, "pending expected events", evq.size(), 0);
    evq.delete();
    for (int k = 0; k < 4; k++) begin
      bit cl;
      cl = (nc > oc) && is_stale(fv[k], nc);
      chk(cache_flags[k] == (cl ? 32'h0 : fv[k]), cl ? "R4" : "R5",
          $sformatf("%s flags of entry %0d", req, k),
          int'(cache_flags[k]), int'(cl ? 32'h0 : fv[k]));
      chk(cache_sel[k] == (cl ? 16'h0 : 16'h0040 + 16'(k * 8)), cl ? "R4" : "R5",
          $sformatf("%s selector of entry %0d", req, k),
          int'(cache_sel[k]), cl ? 0 : 64 + k * 8);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) ld_flags[k] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0,   "R9", "done after reset",   int'(done),   0);
    chk(clr_en == 1'b0, "R9", "clr_en after reset", int'(clr_en), 0);
    chk(rd_idx == 2'd0, "R9", "rd_idx after reset", int'(rd_idx), 0);

    // R2/R3/R4/R5: mixed kinds, level 0 -> 3
    run(2'd0, 2'd3, mk(0,0,0), mk(3,0,0), mk(0,1,1), mk(2,1,0), 1'b0, "R2");
    // R1: every entry stale, consecutive clears in ascending order
    run(2'd1, 2'd2, mk(1,0,0), mk(1,0,0), mk(1,1,0), mk(0,0,0), 1'b0, "R1");
    // R6: same level, nothing touched
    run(2'd2, 2'd2, mk(0,0,0), mk(0,0,0), mk(0,1,0), mk(1,0,0), 1'b0, "R6");
    // R6: inward return, nothing touched
    run(2'd3, 2'd1, mk(0,0,0), mk(0,1,0), mk(0,0,0), mk(0,0,0), 1'b0, "R6");
    // R5 boundary (equal level) and R8 restart ignored mid-sweep
    run(2'd0, 2'd1, mk(1,0,0), mk(0,0,0), mk(3,1,1), 32'h0, 1'b1, "R8");
    // R3: all conforming code at level 0, none cleared
    run(2'd0, 2'd3, mk(0,1,1), mk(0,1,1), mk(1,1,1), mk(2,1,1), 1'b0, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule